// File: doc/BRIEF.md
# Serial 010 Detector with Permanent 100 Lockout

This block watches a one-bit serial stream that is sampled on every rising clock edge. It raises a registered one-cycle flag each time the three most recent bits read 0, 1, 0 in arrival order. The 1, 0, 0 pattern is a lockout: once it has appeared, the flag stays low whatever bits follow, until a synchronous reset re-arms the block.

Detection has two stages. The first is a three-bit shift window with a fill counter. It raises a "hit" flag for 010 and a "kill" flag for 100, but only once three bits have arrived since reset. The second is a three-state controller (idle = 2'b00, match = 2'b01, dead = 2'b10). Its next high bit is the high bit OR kill, and its next low bit is NOT high bit AND hit. The output is the low state bit.

Top module: `seq_guard_detect`

## Requirements
- R1: When the three most recent sampled bits, oldest first, are 0,1,0 and 1,0,0 has not appeared since reset, `hit_out` is 1 in the cycle after the edge that sampled the final 0. In every other case it is 0.
- R2: Matches overlap. The input 0,1,0,1,0 right after reset gives two separate one-cycle pulses.
- R3: Once 1,0,0 has been sampled, `hit_out` stays 0 for all later input until reset.
- R4: The string 0,1,0,0 gives one pulse for its 010 and then locks out. A following 1,0 gives no pulse.
- R5: Bits from before reset never count. After reset, no pattern is recognised until three new bits have been sampled, so the input 1,0 right after reset does not match.
- R6: A synchronous active-high reset clears both stages. `hit_out` reads 0 after a reset edge, and a locked-out block detects 010 again after reset.
- R7: `hit_out` is never 1 in two consecutive cycles.
- R8: The input 1,1,0,1,1,0,1,0,0,1,0 gives exactly one pulse, for the 010 that ends at the eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `bit_in` is sampled here |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| hit_out | output | 1 | Registered match flag |

## Verification
A bit sampled at edge k completes a three-bit window in the first-stage register. The controller picks up that window's flag at edge k+1, so `hit_out` reflects the bit one edge later. A lockout caused by bit k takes effect at the same point. The bench drives each bit at a falling edge and samples `hit_out` at the next falling edge. It compares the sample against the reference result computed for the previous bit, and it counts pulses over whole directed sequences with one flush bit appended, so the last result is also seen.

// File: rtl/seq_guard_pkg.sv
package seq_guard_pkg;

    // Window length and the two recognised patterns, oldest bit in the MSB.
    localparam int          WIN_W    = 3;
    localparam logic [2:0]  PAT_HIT  = 3'b010;
    localparam logic [2:0]  PAT_KILL = 3'b100;

    // Controller encoding: the low bit is the output, the high bit the lockout.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_MATCH = 2'b01,
        ST_DEAD  = 2'b10
    } ctrl_state_e;

endpackage

// File: rtl/seq_guard_window.sv
module seq_guard_window
    import seq_guard_pkg::*;
#(
    parameter int               WIN     = WIN_W,
    parameter logic [WIN-1:0]   HIT_P   = PAT_HIT,
    parameter logic [WIN-1:0]   KILL_P  = PAT_KILL
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic flag_hit,
    output logic flag_kill
);

    localparam int FILL_W = $clog2(WIN + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(WIN);

    typedef struct packed {
        logic [WIN-1:0]    win;
        logic [FILL_W-1:0] fill;
    } win_regs_t;

    win_regs_t win_d, win_q;
    logic      full;

    always_comb begin
        win_d     = win_q;
        win_d.win = {win_q.win[WIN-2:0], bit_in};
        if (win_q.fill != FILL_FULL) begin
            win_d.fill = win_q.fill + 1'b1;
        end
        if (rst) begin
            win_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        win_q <= win_d;
    end

    assign full      = (win_q.fill == FILL_FULL);
    assign flag_hit  = full && (win_q.win == HIT_P);
    assign flag_kill = full && (win_q.win == KILL_P);

    // R5: the fill count never moves backwards outside reset
    a_r5_fill_monotonic: assert property (@(posedge clk) disable iff (rst)
        (win_q.fill != '0) |=> (win_q.fill >= $past(win_q.fill)));

endmodule

// File: rtl/seq_guard_ctrl.sv
module seq_guard_ctrl
    import seq_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flag_hit,
    input  logic flag_kill,
    output logic hit_q
);

    typedef struct packed {
        ctrl_state_e st;
    } ctrl_regs_t;

    ctrl_regs_t ctl_d, ctl_q;
    logic [1:0] st_bits;

    always_comb begin
        st_bits  = ctl_q.st;
        ctl_d.st = ctrl_state_e'({st_bits[1] | flag_kill,
                                  ~st_bits[1] & flag_hit});
        if (rst) begin
            ctl_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign hit_q = ctl_q.st[0];

    // R3: lockout state is held until reset
    a_r3_dead_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_DEAD) |=> (ctl_q.st == ST_DEAD));

    // R6: the unused code is never reached
    a_r6_state_legal: assert property (@(posedge clk) disable iff (rst)
        ctl_q.st != 2'b11);

endmodule

// File: rtl/seq_guard_detect.sv
module seq_guard_detect
    import seq_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic hit_out
);

    logic flag_hit;
    logic flag_kill;

    seq_guard_window #(
        .WIN    (WIN_W),
        .HIT_P  (PAT_HIT),
        .KILL_P (PAT_KILL)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .flag_hit  (flag_hit),
        .flag_kill (flag_kill)
    );

    seq_guard_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flag_hit  (flag_hit),
        .flag_kill (flag_kill),
        .hit_q     (hit_out)
    );

    // Edges seen since reset, saturating; used only by the checks below.
    logic [2:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (rst)                    since_rst_q <= '0;
        else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
    end

    // R1: a pulse needs a 010 window one cycle earlier
    a_r1_hit_follows_pattern: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> $past(flag_hit));

    // R3: a 100 window suppresses the next output
    a_r3_kill_blocks_next: assert property (@(posedge clk) disable iff (rst)
        flag_kill |=> !hit_out);

    // R7: no two pulses back to back
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        hit_out |=> !hit_out);

    // R5: first possible pulse is four edges after reset release
    a_r5_hit_after_fill: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> (since_rst_q >= 3'd4));

endmodule

// File: tb/seq_guard_detect_bench.sv
module seq_guard_detect_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic hit_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [2:0] m_hist;
    int         m_cnt;
    bit         m_seen_kill;
    bit         exp_prev;
    int         pulses;

    always #5 clk = ~clk;

    seq_guard_detect u_seq_guard_detect (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .hit_out (hit_out)
    );

    function automatic bit model_next(input bit b);
        m_hist = {m_hist[1:0], b};
        if (m_cnt < 3) m_cnt++;
        if (m_cnt == 3 && m_hist == 3'b100) m_seen_kill = 1;
        return (m_cnt == 3 && m_hist == 3'b010 && !m_seen_kill);
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: hit_out=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive one bit, sample result of the previous bit at the next falling edge
    task automatic step(input bit b, input string tag);
        bit_in = b;
        @(negedge clk);
        check(hit_out, exp_prev, tag);
        if (hit_out === 1'b1) pulses++;
        exp_prev = model_next(b);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(hit_out, 1'b0, "R6");
        rst = 1'b0;
        m_hist = '0; m_cnt = 0; m_seen_kill = 0; exp_prev = 0;
        pulses = 0;
    endtask

    task automatic run_seq(input logic [15:0] bits, input int len, input string tag);
        for (int i = len - 1; i >= 0; i--) step(bits[i], tag);
        step(1'b1, tag);   // flush so the last result is observed
    endtask

    task automatic count_check(input int exp, input string tag);
        checks++;
        if (pulses != exp) begin
            failures++;
            $display("FAIL %s: pulses=%0d expected=%0d", tag, pulses, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R6: reset state
        do_reset();

        // R1 and R2: overlapping matches
        run_seq(16'b01010, 5, "R2");
        count_check(2, "R2");

        // R8: directed string from the requirement
        do_reset();
        run_seq(16'b11011010010, 11, "R8");
        count_check(1, "R8");

        // R4: 0100 locks out
        do_reset();
        run_seq(16'b010010, 6, "R4");
        count_check(1, "R4");

        // R5: too few bits after reset, history before reset ignored
        do_reset();
        bit_in = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_seq(16'b10, 2, "R5");
        count_check(0, "R5");

        // R3: lockout then long random tail
        do_reset();
        run_seq(16'b100, 3, "R3");
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), "R3");
        run_seq(16'b01010, 5, "R3");
        count_check(0, "R3");

        // R6: re-armed after reset
        do_reset();
        run_seq(16'b010, 3, "R6");
        count_check(1, "R6");

        // R1 / R7: random streams with periodic reset
        void'($urandom(32'd12345));
        for (int r = 0; r < 40; r++) begin
            do_reset();
            for (int i = 0; i < 40; i++) begin
                bit prev;
                prev = hit_out;
                step(1'($urandom_range(0, 1)), "R1");
                if (prev === 1'b1) check(hit_out, 1'b0, "R7");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule